// File: doc/BRIEF.md
# Write-only I2C display data front end

This block is the bus-facing half of a segment display driver. It listens to an I2C bus as a slave that can only be written. It samples SCL and SDA into the system clock domain and finds START, repeated START and STOP conditions. It then splits each transfer into an address byte, control bytes and payload bytes. The address is the fixed pattern 0111 00x, where x is a strap pin, so two drivers can share one bus. A read request is never answered.

Each control byte sets the destination of the bytes that follow it, which is either the command register or the display data memory. It also sets whether more control bytes are coming. Display bytes land in a 60-entry memory through a pointer that advances by itself after each byte. The display side reads this memory through a plain read port. Two command patterns are handled inside the block: one loads the pointer and the other picks which cascaded unit takes display data. Every other command byte is passed out on a one-cycle strobe.

Top module: `disp_i2c_wr_front`

## Requirements
- R1: An address byte whose upper seven bits are 0111 00 followed by the strap_sa0 level, with bit 0 (R/W) equal to 0, is acknowledged. The block pulls SDA low for the ninth clock of that byte.
- R2: An address byte with R/W = 1, or one with a different address, is not acknowledged. After it, every byte up to the next START or STOP gets no acknowledge, writes no memory location and raises no command strobe.
- R3: The first byte after a matched address is a control byte, and it is acknowledged. Its bit 7 is the continue flag and its bit 6 is the destination select. Bits 5..0 have no effect.
- R4: With the continue flag at 0, every later byte of the transfer goes to the selected destination. With the continue flag at 1, exactly one payload byte follows, and the byte after it is again a control byte.
- R5: With destination select at 1, a display byte is written at the pointer and the pointer then advances by one. After location 59 the pointer wraps to 0.
- R6: With destination select at 0, a command byte of the form 00pppppp is acknowledged and loads pppppp into the pointer. If the loaded value is 60..63, the next display byte is dropped and the pointer goes to 0.
- R7: A command byte of the form 11100sss is acknowledged and stores sss as the selected unit. Display bytes are acknowledged and written only while sss equals unit_id. Otherwise they get no acknowledge, nothing is written and the pointer does not change.
- R8: Every other command byte is acknowledged and appears on cmd_byte, with cmd_valid high for exactly one clock.
- R9: STOP ends the transfer. A repeated START begins a new address phase. Pointer and selected unit keep their values across transfers.
- R10: The acknowledge pull is released at the SCL falling edge that ends the ninth clock.
- R11: After reset, sda_pull_o and cmd_valid are 0, the pointer and the selected unit are 0, and every memory location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | 1 drives SDA low (open drain) |
| strap_sa0 | input | 1 | Address bit 1 strap |
| unit_id | input | 3 | This unit's position in a cascade |
| cmd_valid | output | 1 | One-cycle strobe for a passed-out command |
| cmd_byte | output | 8 | Passed-out command byte |
| rd_addr | input | 6 | Display memory read address |
| rd_data | output | 8 | Display memory read data (0 beyond the last location) |

## Verification
Four properties are checked on every cycle. The acknowledge pull only ever rises while SCL is low. Each command strobe lasts one cycle. Each memory write moves the pointer by one step or wraps it at the end. An ignored transfer stays silent, with no pull, no write and no strobe. The checker also confirms that STOP and START force their states and that writes only happen for the selected unit. Other behaviour can only be shown by the bench's bus scenarios: control-byte framing under both continue settings, pointer loads including out-of-range values, and unit selection. The same goes for strap matching, read rejection and pointer persistence across a repeated START, all of which the bench observes at the acknowledge bit, the memory read port and the command strobe.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

    localparam logic [5:0] ADDR_FIXED = 6'b011100;
    localparam int         UNIT_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_DATA,
        ST_SKIP
    } dwf_state_e;

    typedef struct packed {
        logic more_ctrl;   // continue flag
        logic to_ram;      // destination select
    } dwf_ctrl_t;

    function automatic logic f_addr_hit(input logic [7:0] b, input logic strap);
        return (b[7:1] == {ADDR_FIXED, strap}) && !b[0];
    endfunction

    function automatic dwf_ctrl_t f_ctrl(input logic [7:0] b);
        dwf_ctrl_t c;
        c.more_ctrl = b[7];
        c.to_ram    = b[6];
        return c;
    endfunction

    function automatic logic f_is_ptr_load(input logic [7:0] b);
        return b[7:6] == 2'b00;
    endfunction

    function automatic logic f_is_unit_sel(input logic [7:0] b);
        return b[7:3] == 5'b11100;
    endfunction

endpackage

// File: rtl/dwf_line_cond.sv
module dwf_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_ff[SYNC_STAGES-1];
            sda_q  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dwf_link.sv
module dwf_link (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       ack_i,
    output logic       byte_rdy,
    output logic [7:0] rx_byte,
    output logic       pull_o
);
    logic [7:0] shreg;
    logic [3:0] bit_cnt;
    logic       ack_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            pull_o  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            pull_o  <= 1'b0;
        end else if (scl_rise && !ack_ph && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
            if (ack_ph) begin
                ack_ph  <= 1'b0;
                pull_o  <= 1'b0;
                bit_cnt <= '0;
            end else if (bit_cnt == 4'd8) begin
                ack_ph <= 1'b1;
                pull_o <= ack_i;
            end
        end
    end

    assign byte_rdy = scl_fall && !ack_ph && (bit_cnt == 4'd8) && !start_det && !stop_det;
    assign rx_byte  = shreg;
endmodule

// File: rtl/dwf_proto.sv
module dwf_proto
    import dwf_pkg::*;
#(
    parameter int DEPTH = 60,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_rdy,
    input  logic [7:0]        rx_byte,
    input  logic              strap_sa0,
    input  logic [UNIT_W-1:0] unit_id,
    output logic              ack_o,
    output logic              wr_en,
    output logic [PW-1:0]     wr_addr,
    output logic [7:0]        wr_data,
    output logic              cmd_valid,
    output logic [7:0]        cmd_byte,
    output dwf_state_e        state_o,
    output logic [PW-1:0]     ptr_o,
    output logic [UNIT_W-1:0] sel_o
);
    dwf_state_e        st;
    dwf_ctrl_t         ctl;
    logic [PW-1:0]     ptr;
    logic [UNIT_W-1:0] sel;
    logic              unit_hit;

    function automatic logic [PW-1:0] f_step(input logic [PW-1:0] p);
        if (p >= PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    assign unit_hit = (sel == unit_id);

    always_comb begin
        case (st)
            ST_ADDR: ack_o = f_addr_hit(rx_byte, strap_sa0);
            ST_CTRL: ack_o = 1'b1;
            ST_DATA: ack_o = ctl.to_ram ? unit_hit : 1'b1;
            default: ack_o = 1'b0;
        endcase
    end

    assign wr_en   = byte_rdy && (st == ST_DATA) && ctl.to_ram && unit_hit
                     && (ptr < PW'(DEPTH));
    assign wr_addr = ptr;
    assign wr_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ctl       <= '0;
            ptr       <= '0;
            sel       <= '0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (stop_det) begin
                st <= ST_IDLE;
            end else if (start_det) begin
                st <= ST_ADDR;
            end else if (byte_rdy) begin
                case (st)
                    ST_ADDR: st <= f_addr_hit(rx_byte, strap_sa0) ? ST_CTRL : ST_SKIP;
                    ST_CTRL: begin
                        ctl <= f_ctrl(rx_byte);
                        st  <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (ctl.to_ram) begin
                            if (unit_hit) ptr <= f_step(ptr);
                        end else if (f_is_ptr_load(rx_byte)) begin
                            ptr <= PW'(rx_byte[5:0]);
                        end else if (f_is_unit_sel(rx_byte)) begin
                            sel <= rx_byte[UNIT_W-1:0];
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_byte  <= rx_byte;
                        end
                        if (ctl.more_ctrl) st <= ST_CTRL;
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    assign state_o = st;
    assign ptr_o   = ptr;
    assign sel_o   = sel;
endmodule

// File: rtl/dwf_ram.sv
module dwf_ram #(
    parameter int DEPTH = 60,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [PW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = (rd_addr < PW'(DEPTH)) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/disp_i2c_wr_front.sv
module disp_i2c_wr_front
    import dwf_pkg::*;
#(
    parameter int DEPTH       = 60,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              strap_sa0,
    input  logic [UNIT_W-1:0] unit_id,
    output logic              cmd_valid,
    output logic [7:0]        cmd_byte,
    input  logic [PW-1:0]     rd_addr,
    output logic [7:0]        rd_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ack, byte_rdy, wr_en;
    logic [7:0] rx_byte, wr_data;
    logic [PW-1:0] wr_addr, ptr;
    logic [UNIT_W-1:0] sel;
    dwf_state_e st;

    dwf_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dwf_link u_link (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .ack_i(ack),
        .byte_rdy(byte_rdy), .rx_byte(rx_byte), .pull_o(sda_pull_o)
    );

    dwf_proto #(.DEPTH(DEPTH)) u_proto (
        .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
        .byte_rdy(byte_rdy), .rx_byte(rx_byte), .strap_sa0(strap_sa0), .unit_id(unit_id),
        .ack_o(ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .state_o(st), .ptr_o(ptr), .sel_o(sel)
    );

    dwf_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/dwf_checks.sv
module dwf_checks
    import dwf_pkg::*;
#(
    parameter int DEPTH = 60,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_pull_o,
    input logic              cmd_valid,
    input logic              wr_en,
    input logic [PW-1:0]     wr_addr,
    input logic [PW-1:0]     ptr,
    input logic [UNIT_W-1:0] sel,
    input logic [UNIT_W-1:0] unit_id,
    input dwf_state_e        st
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_s); // R10

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R8

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == PW'(DEPTH - 1)) |=> (ptr == '0)); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr < PW'(DEPTH - 1)) |=> (ptr == $past(wr_addr) + PW'(1))); // R5

    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sel == unit_id)); // R7

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> (!sda_pull_o && !wr_en && !cmd_valid)); // R2

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE)); // R9

    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det) |=> (st == ST_ADDR)); // R9
endmodule

bind disp_i2c_wr_front dwf_checks #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
    .sda_pull_o(sda_pull_o), .cmd_valid(cmd_valid), .wr_en(wr_en), .wr_addr(wr_addr),
    .ptr(ptr), .sel(sel), .unit_id(unit_id), .st(st)
);

// File: tb/tb_disp_i2c_wr_front.sv
`timescale 1ns/1ps
module tb_disp_i2c_wr_front;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_i, sda_pull_o, strap_sa0 = 1'b0;
    logic [2:0] unit_id = 3'd0;
    logic cmd_valid;
    logic [7:0] cmd_byte, rd_data;
    logic [5:0] rd_addr = '0;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign sda_i = sda_m & ~sda_pull_o;

    disp_i2c_wr_front dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_i), .sda_pull_o(sda_pull_o),
        .strap_sa0(strap_sa0), .unit_id(unit_id), .cmd_valid(cmd_valid),
        .cmd_byte(cmd_byte), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = !sda_i;
        wq(); scl_m = 1'b0; wq();
        chk(ack == exp_ack, req, "ack bit", int'(ack), int'(exp_ack));
        chk(!sda_pull_o, "R10", "pull released after ninth clock", int'(sda_pull_o), 0);
    endtask

    task automatic ram_chk(input int a, input logic [7:0] exp, input string req);
        @(negedge clk); rd_addr = 6'(a); #1;
        chk(rd_data == exp, req, $sformatf("ram[%0d]", a), int'(rd_data), int'(exp));
    endtask

    // scoreboard monitor for passed-out commands
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected command strobe", int'(cmd_byte), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(cmd_byte == e, "R8", "command byte", int'(cmd_byte), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!sda_pull_o, "R11", "pull after reset", int'(sda_pull_o), 0);
        chk(!cmd_valid, "R11", "cmd_valid after reset", int'(cmd_valid), 0);
        ram_chk(0, 8'h00, "R11");
        ram_chk(59, 8'h00, "R11");

        // R1 R3 R6 R7 R8: commands only, continue flag 0
        bus_start();
        send(8'h70, 1'b1, "R1");
        send(8'h00, 1'b1, "R3");
        send(8'h05, 1'b1, "R6");
        send(8'hE0, 1'b1, "R7");
        exp_q.push_back(8'h47);
        send(8'h47, 1'b1, "R8");
        bus_stop();

        // R4 R5: continue flag 1 then a control byte with junk low bits
        bus_start();
        send(8'h70, 1'b1, "R1");
        send(8'hC0, 1'b1, "R3");
        send(8'hA1, 1'b1, "R5");
        send(8'h7F, 1'b1, "R4");
        send(8'hB2, 1'b1, "R5");
        send(8'hB3, 1'b1, "R4");
        bus_stop();
        ram_chk(5, 8'hA1, "R5");
        ram_chk(6, 8'hB2, "R4");
        ram_chk(7, 8'hB3, "R4");

        // R5 wrap, R9 repeated start keeps pointer
        bus_start();
        send(8'h70, 1'b1, "R1");
        send(8'h80, 1'b1, "R3");
        send(8'h3A, 1'b1, "R6");
        send(8'h40, 1'b1, "R4");
        send(8'h11, 1'b1, "R5");
        send(8'h22, 1'b1, "R5");
        send(8'h33, 1'b1, "R5");
        bus_start();
        send(8'h70, 1'b1, "R9");
        send(8'h40, 1'b1, "R9");
        send(8'h44, 1'b1, "R9");
        bus_stop();
        ram_chk(58, 8'h11, "R5");
        ram_chk(59, 8'h22, "R5");
        ram_chk(0, 8'h33, "R5");
        ram_chk(1, 8'h44, "R9");

        // R2 read request ignored
        bus_start();
        send(8'h71, 1'b0, "R2");
        send(8'h00, 1'b0, "R2");
        send(8'h47, 1'b0, "R2");
        bus_stop();
        // R2 other address ignored
        bus_start();
        send(8'h72, 1'b0, "R2");
        send(8'h40, 1'b0, "R2");
        send(8'h99, 1'b0, "R2");
        bus_stop();
        ram_chk(2, 8'h00, "R2");

        // R1 strap level 1
        strap_sa0 = 1'b1;
        bus_start();
        send(8'h70, 1'b0, "R1");
        bus_stop();
        bus_start();
        send(8'h72, 1'b1, "R1");
        send(8'h00, 1'b1, "R3");
        send(8'hE3, 1'b1, "R7");
        bus_stop();

        // R7 unselected unit: no ack, no write, pointer holds
        bus_start();
        send(8'h72, 1'b1, "R1");
        send(8'h40, 1'b1, "R3");
        send(8'h55, 1'b0, "R7");
        bus_stop();
        ram_chk(2, 8'h00, "R7");
        bus_start();
        send(8'h72, 1'b1, "R1");
        send(8'h80, 1'b1, "R3");
        send(8'hE0, 1'b1, "R7");
        send(8'h40, 1'b1, "R3");
        send(8'h66, 1'b1, "R7");
        bus_stop();
        ram_chk(2, 8'h66, "R7");

        // R6 out-of-range pointer load: byte dropped, pointer to 0
        bus_start();
        send(8'h72, 1'b1, "R1");
        send(8'h80, 1'b1, "R3");
        send(8'h3E, 1'b1, "R6");
        send(8'h40, 1'b1, "R3");
        send(8'h77, 1'b1, "R6");
        send(8'h88, 1'b1, "R6");
        bus_stop();
        ram_chk(0, 8'h88, "R6");
        ram_chk(59, 8'h22, "R6");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "pending expected commands", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule